// File: doc/BRIEF.md
# Shadow-Loaded PWM Channel Bank

This block holds a configurable number of independent PWM channels behind one register write/read port. Each channel has two staging registers, a frequency step and an on-time threshold, plus a control register with an output-enable bit and a self-clearing commit bit. Software writes the staging registers, then sets the commit bit. The hardware keeps the commit bit high for a fixed number of clocks and then drops it. On that same clock it copies the staged values into the running generator. Software polls the commit bit to learn when the new settings are live.

Each generator adds its step to a wrapping phase accumulator on every clock. The output is high while the upper eight accumulator bits are below the on-time threshold. Settings can be changed while the output runs.

The commit logic has a deliberate hazard. If a second commit is written while one is still pending, the bit locks high and never clears. This happens, for example, when a read-modify-write sets the enable bit and writes back a stale commit bit of 1. Only reset, or writing the commit bit as 0, releases the lock.

Top module: `pwm_shadow_bank`

## Requirements
- R1: After a synchronous reset every output is low, and every control, step and threshold register reads 0.
- R2: Writes to the step register (address 1) and the threshold register (address 2, bits 7:0) can be read back. They have no effect on the output until a commit completes.
- R3: Writing 1 to the commit bit (address 0, bit 0) while no commit is pending makes that bit read 1 for exactly UPD_DLY clocks (default 4) after the write edge. It then reads 0.
- R4: On the clock where the commit bit clears, the staged step and threshold become active, and the phase accumulator restarts from zero.
- R5: Writing 1 to the commit bit while a commit is pending locks it at 1 with no copy ever made. A later control write with bit 0 clear unlocks it without copying.
- R6: While the enable bit (address 0, bit 1) is 0, the output is low and the accumulator is held at zero.
- R7: While enabled, the accumulator grows by the active step each clock, modulo 2^BASE_W. The registered output is high exactly when the top 8 accumulator bits are below the active threshold, so a threshold of 0 gives a constant low.
- R8: A commit issued while the output is enabled changes the period and duty without disabling the output.
- R9: Channels selected by the channel index are fully independent of one another.
- R10: Writes to address 3 are ignored, and reads of address 3 return 0.
- R11: Read data is registered: it shows the selected register's value from before the edge that captures the read address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_chan | input | CH_W | Channel selected for the write |
| wr_addr | input | 2 | Register address for the write |
| wr_data | input | BASE_W | Write data |
| rd_chan | input | CH_W | Channel selected for the read |
| rd_addr | input | 2 | Register address for the read |
| rd_data | output | BASE_W | Registered read data |
| pwm_o | output | NUM_CH | Registered PWM outputs, one per channel |

## Verification
The hardest state to reach is the locked commit. It needs a second commit write to land inside the short pending window, and a polling loop cannot do that, so the stimulus issues two control writes with bit 0 set on consecutive write slots. The bench then confirms through the read port that the bit stays locked for many clocks, and confirms from the output's duty that the staged threshold was never applied. It also checks that an unlock write releases the bit without making the copy, and that a fresh commit afterwards applies normally while the output keeps running.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STEP = 2'd1,
    SEL_THR  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int CTRL_COMMIT_BIT = 0;
  localparam int CTRL_ENABLE_BIT = 1;
  localparam int THR_W           = 8;
endpackage

// File: rtl/pwm_commit_ctrl.sv
module pwm_commit_ctrl
  import pwm_shadow_pkg::*;
#(
  parameter int BASE_W  = 16,
  parameter int UPD_DLY = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  reg_sel_e          sel_i,
  input  logic [BASE_W-1:0] data_i,
  output logic              enable_o,
  output logic              commit_o,
  output logic [BASE_W-1:0] stage_step_o,
  output logic [THR_W-1:0]  stage_thr_o,
  output logic [BASE_W-1:0] act_step_o,
  output logic [THR_W-1:0]  act_thr_o,
  output logic              restart_o
);
  localparam int CNT_W = (UPD_DLY > 1) ? $clog2(UPD_DLY) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(UPD_DLY - 1);

  logic             commit_q, locked_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ctrl_wr, unlock_wr;

  assign ctrl_wr   = wr_i && (sel_i == SEL_CTRL);
  assign unlock_wr = ctrl_wr && !data_i[CTRL_COMMIT_BIT];
  assign restart_o = commit_q && !locked_q && (cnt_q == LAST) && !ctrl_wr;
  assign commit_o  = commit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_o     <= 1'b0;
      commit_q     <= 1'b0;
      locked_q     <= 1'b0;
      cnt_q        <= '0;
      stage_step_o <= '0;
      stage_thr_o  <= '0;
      act_step_o   <= '0;
      act_thr_o    <= '0;
    end else begin
      if (ctrl_wr) begin
        enable_o <= data_i[CTRL_ENABLE_BIT];
        if (data_i[CTRL_COMMIT_BIT]) begin
          if (commit_q) begin
            locked_q <= 1'b1;
          end else begin
            commit_q <= 1'b1;
            cnt_q    <= '0;
          end
        end else begin
          commit_q <= 1'b0;
          locked_q <= 1'b0;
          cnt_q    <= '0;
        end
      end else if (restart_o) begin
        commit_q   <= 1'b0;
        cnt_q      <= '0;
        act_step_o <= stage_step_o;
        act_thr_o  <= stage_thr_o;
      end else if (commit_q && !locked_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (wr_i && sel_i == SEL_STEP) stage_step_o <= data_i;
      if (wr_i && sel_i == SEL_THR)  stage_thr_o  <= data_i[THR_W-1:0];
    end
  end

  p_lock_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (locked_q && !unlock_wr) |=> (commit_q && locked_q));
  p_active_only_on_commit_r4: assert property (@(posedge clk) disable iff (rst)
    !commit_q |=> ($stable(act_step_o) && $stable(act_thr_o)));
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  p_unlock_clears_r5: assert property (@(posedge clk) disable iff (rst)
    unlock_wr |=> (!commit_q && !locked_q));
endmodule

// File: rtl/pwm_phase_core.sv
module pwm_phase_core
  import pwm_shadow_pkg::*;
#(
  parameter int BASE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable_i,
  input  logic              restart_i,
  input  logic [BASE_W-1:0] step_i,
  input  logic [THR_W-1:0]  thr_i,
  output logic              pwm_o
);
  logic [BASE_W-1:0] acc_q;
  logic [THR_W-1:0]  phase_top;

  assign phase_top = acc_q[BASE_W-1 -: THR_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      pwm_o <= 1'b0;
    end else begin
      pwm_o <= enable_i && (phase_top < thr_i);
      if (!enable_i || restart_i) acc_q <= '0;
      else                        acc_q <= acc_q + step_i;
    end
  end

  p_disabled_low_r6: assert property (@(posedge clk) disable iff (rst)
    !enable_i |=> (!pwm_o && acc_q == '0));
  p_zero_thr_low_r7: assert property (@(posedge clk) disable iff (rst)
    (thr_i == '0) |=> !pwm_o);
  p_restart_zero_r4: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (acc_q == '0));
endmodule

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank
  import pwm_shadow_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int BASE_W  = 16,
  parameter int UPD_DLY = 4,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic [1:0]        wr_addr,
  input  logic [BASE_W-1:0] wr_data,
  input  logic [CH_W-1:0]   rd_chan,
  input  logic [1:0]        rd_addr,
  output logic [BASE_W-1:0] rd_data,
  output logic [NUM_CH-1:0] pwm_o
);
  logic [BASE_W-1:0] stage_step [NUM_CH];
  logic [THR_W-1:0]  stage_thr  [NUM_CH];
  logic              ch_enable  [NUM_CH];
  logic              ch_commit  [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic              wr_sel, restart;
    logic [BASE_W-1:0] act_step;
    logic [THR_W-1:0]  act_thr;

    assign wr_sel = wr_en && (wr_chan == CH_W'(g));

    pwm_commit_ctrl #(.BASE_W(BASE_W), .UPD_DLY(UPD_DLY)) u_ctrl (
      .clk          (clk),
      .rst          (rst),
      .wr_i         (wr_sel),
      .sel_i        (reg_sel_e'(wr_addr)),
      .data_i       (wr_data),
      .enable_o     (ch_enable[g]),
      .commit_o     (ch_commit[g]),
      .stage_step_o (stage_step[g]),
      .stage_thr_o  (stage_thr[g]),
      .act_step_o   (act_step),
      .act_thr_o    (act_thr),
      .restart_o    (restart)
    );

    pwm_phase_core #(.BASE_W(BASE_W)) u_core (
      .clk       (clk),
      .rst       (rst),
      .enable_i  (ch_enable[g]),
      .restart_i (restart),
      .step_i    (act_step),
      .thr_i     (act_thr),
      .pwm_o     (pwm_o[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (int'(rd_chan) >= NUM_CH) begin
      rd_data <= '0;
    end else begin
      case (reg_sel_e'(rd_addr))
        SEL_CTRL: begin
          rd_data <= '0;
          rd_data[CTRL_COMMIT_BIT] <= ch_commit[rd_chan];
          rd_data[CTRL_ENABLE_BIT] <= ch_enable[rd_chan];
        end
        SEL_STEP: rd_data <= stage_step[rd_chan];
        SEL_THR:  rd_data <= BASE_W'(stage_thr[rd_chan]);
        default:  rd_data <= '0;
      endcase
    end
  end

  p_none_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == 2'd3) |=> (rd_data == '0));
endmodule

// File: tb/pwm_shadow_bank_tb.sv
module pwm_shadow_bank_tb;
  localparam int NUM_CH = 2;
  localparam int BASE_W = 16;
  localparam int DLY    = 4;
  localparam int CH_W   = 1;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0;
  logic [CH_W-1:0] wr_chan = '0, rd_chan = '0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [BASE_W-1:0] wr_data = '0;
  logic [BASE_W-1:0] rd_data;
  logic [NUM_CH-1:0] pwm_o;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_shadow_bank #(.NUM_CH(NUM_CH), .BASE_W(BASE_W), .UPD_DLY(DLY)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_chan(wr_chan), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_chan(rd_chan), .rd_addr(rd_addr), .rd_data(rd_data),
    .pwm_o(pwm_o));

  // Behavioural reference model
  int m_en[NUM_CH], m_pend[NUM_CH], m_lock[NUM_CH], m_cnt[NUM_CH];
  int m_ss[NUM_CH], m_st[NUM_CH], m_as[NUM_CH], m_at[NUM_CH];
  int m_acc[NUM_CH], m_pwm[NUM_CH];
  int m_rd;
  bit m_live = 0;

  always @(posedge clk) begin
    int rd_next;
    rd_next = 0;
    if (int'(rd_addr) == 0) rd_next = m_en[rd_chan] * 2 + m_pend[rd_chan];
    else if (int'(rd_addr) == 1) rd_next = m_ss[rd_chan];
    else if (int'(rd_addr) == 2) rd_next = m_st[rd_chan];
    for (int c = 0; c < NUM_CH; c++) begin
      if (rst) begin
        m_en[c] = 0; m_pend[c] = 0; m_lock[c] = 0; m_cnt[c] = 0;
        m_ss[c] = 0; m_st[c] = 0; m_as[c] = 0; m_at[c] = 0;
        m_acc[c] = 0; m_pwm[c] = 0;
      end else begin
        bit wr_here, ctrl_w, fire;
        int old_ss, old_st;
        wr_here = wr_en && int'(wr_chan) == c;
        ctrl_w  = wr_here && wr_addr == 2'd0;
        fire    = m_pend[c] == 1 && m_lock[c] == 0 && m_cnt[c] == DLY - 1 && !ctrl_w;
        old_ss  = m_ss[c];
        old_st  = m_st[c];
        m_pwm[c] = (m_en[c] == 1 && (m_acc[c] >> (BASE_W - 8)) < m_at[c]) ? 1 : 0;
        if (m_en[c] == 0 || fire) m_acc[c] = 0;
        else m_acc[c] = (m_acc[c] + m_as[c]) % (1 << BASE_W);
        if (ctrl_w) begin
          m_en[c] = wr_data[1];
          if (wr_data[0]) begin
            if (m_pend[c] == 1) m_lock[c] = 1;
            else begin m_pend[c] = 1; m_cnt[c] = 0; end
          end else begin
            m_pend[c] = 0; m_lock[c] = 0; m_cnt[c] = 0;
          end
        end else if (fire) begin
          m_pend[c] = 0; m_cnt[c] = 0; m_as[c] = old_ss; m_at[c] = old_st;
        end else if (m_pend[c] == 1 && m_lock[c] == 0) begin
          m_cnt[c]++;
        end
        if (wr_here && wr_addr == 2'd1) m_ss[c] = int'(wr_data);
        if (wr_here && wr_addr == 2'd2) m_st[c] = int'(wr_data[7:0]);
      end
    end
    m_rd = rst ? 0 : rd_next;
    m_live = 1;
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (m_live && !done) begin
      for (int c = 0; c < NUM_CH; c++) begin
        checks++;
        if (int'(pwm_o[c]) != m_pwm[c]) begin
          errors++;
          $display("FAIL R7 ch%0d pwm actual=%0d expected=%0d t=%0t", c, pwm_o[c], m_pwm[c], $time);
        end
      end
      checks++;
      if (int'(rd_data) != m_rd) begin
        errors++;
        $display("FAIL R11 rd_data actual=%0d expected=%0d t=%0t", rd_data, m_rd, $time);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_chan = CH_W'(ch); wr_addr = 2'(a); wr_data = BASE_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ch, input int a, output int v);
    rd_chan = CH_W'(ch); rd_addr = 2'(a);
    @(negedge clk);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic count_high(input int ch, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hi += int'(pwm_o[ch]);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v, hi;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pwm", int'(pwm_o), 0);
    rd(0, 0, v); chk("R1 ctrl", v, 0);
    rd(1, 1, v); chk("R1 step", v, 0);
    // R2 staging without effect
    wr(0, 1, 4096); wr(0, 2, 128);
    rd(0, 1, v); chk("R2 step readback", v, 4096);
    rd(0, 2, v); chk("R2 thr readback", v, 128);
    wr(0, 0, 2);
    count_high(0, 16, hi); chk("R2 no effect before commit", hi, 0);
    // R3 commit timing
    rd_chan = 0; rd_addr = 0;
    wr(0, 0, 3);
    for (int k = 1; k <= DLY + 1; k++) begin
      @(negedge clk);
      chk("R3 commit bit", int'(rd_data[0]), (k <= DLY) ? 1 : 0);
    end
    // R4 applied: period 16, half duty
    count_high(0, 16, hi); chk("R4 duty after commit", hi, 8);
    // R5 lock-up by double commit
    wr(0, 2, 64);
    wr(0, 0, 3); wr(0, 0, 3);
    idle(20);
    rd(0, 0, v); chk("R5 locked ctrl", v, 3);
    count_high(0, 16, hi); chk("R5 no copy while locked", hi, 8);
    wr(0, 0, 2);
    rd(0, 0, v); chk("R5 unlock ctrl", v, 2);
    count_high(0, 16, hi); chk("R5 no copy on unlock", hi, 8);
    // R8 commit while running
    wr(0, 0, 3); idle(6);
    count_high(0, 16, hi); chk("R8 quarter duty", hi, 4);
    wr(0, 2, 255); wr(0, 0, 3); idle(6);
    count_high(0, 16, hi); chk("R8 R7 full duty", hi, 16);
    // R9 second channel independent
    wr(1, 1, 8192); wr(1, 2, 64); wr(1, 0, 3); idle(6);
    count_high(1, 8, hi); chk("R9 ch1 duty", hi, 2);
    count_high(0, 16, hi); chk("R9 ch0 unaffected", hi, 16);
    // R6 disable
    wr(0, 0, 0); idle(1);
    count_high(0, 20, hi); chk("R6 disabled low", hi, 0);
    count_high(1, 8, hi); chk("R9 ch1 still runs", hi, 2);
    wr(0, 0, 2); idle(1);
    count_high(0, 16, hi); chk("R6 re-enable", hi, 16);
    // R10 unused address
    wr(0, 3, 77);
    rd(0, 3, v); chk("R10 read zero", v, 0);
    rd(0, 1, v); chk("R10 step untouched", v, 4096);
    rd(0, 2, v); chk("R10 thr untouched", v, 255);
    idle(2);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule